// File: doc/BRIEF.md
# Atomic Compare-Swap and Masked-Swap Unit

This block carries out indivisible read-modify-write operations on one 32-bit memory word. It has two operations. In a conditional swap, the block writes a new word only when the current memory content equals a compare value. Otherwise it writes the old word back unchanged. In a masked swap, only the bits selected by a mask are replaced. In both operations the word that was in memory before the write comes back to the caller. The caller uses that word to replace its data register.

The caller supplies the following with a one-cycle `op_valid` strobe:

- a 6-bit sub-opcode;
- a base address;
- a 10-bit signed offset;
- the data register value;
- the paired register value, which is the compare value or the mask.

The sub-opcode picks the operation and one of three addressing modes: short offset, post-increment or pre-increment. The block reports the updated base next to the old memory word.

On the memory side there is one word port that the block owns. The port gives a read request and then a write request to the same address. A lock signal is held over the whole read-then-write sequence, so no other master can access memory between the two. A sub-opcode outside the six legal codes raises a one-cycle illegal flag and makes no memory access.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Conditional swap (sub-opcode low nibble 3): when `pair_in` equals the word read, the write phase stores `data_in`.
- R2: Conditional swap with `pair_in` different from the word read: the write phase still takes place, and it stores the word read, unchanged.
- R3: Masked swap (sub-opcode low nibble 2): the word written is `(data_in & pair_in) | (old & ~pair_in)`.
- R4: For both operations, `old_out` holds the word read when `done` pulses.
- R5: Short-offset mode (sub-opcode bits [5:4] = 2'b10): the access address is base + offset, and `base_out` equals the unchanged base.
- R6: Post-increment mode (bits [5:4] = 2'b00): the access address is the old base, and `base_out` is base + offset.
- R7: Pre-increment mode (bits [5:4] = 2'b01): both the access address and `base_out` are base + offset.
- R8: The legal sub-opcodes are exactly 0x23, 0x03 and 0x13 (conditional swap) and 0x22, 0x02 and 0x12 (masked swap).
- R9: `mem_lock` is high with every request. It rises with a read request and stays high without a gap until the write is acknowledged. The write goes to the address that was read.
- R10: An illegal sub-opcode makes `illegal` pulse for one cycle, on the cycle after the strobe. No memory request and no `done` pulse follow.
- R11: The offset is a signed two's-complement value and is sign-extended before any addition.
- R12: `op_valid` is ignored while `busy` is high. The running operation completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe, taken only while idle |
| op_code | input | 6 | Sub-opcode selecting the operation and the addressing mode |
| base_in | input | 32 | Base address register value |
| offset_in | input | 10 | Signed address offset |
| data_in | input | 32 | Data register value: the new word, or the bits to insert |
| pair_in | input | 32 | Paired register value: the compare value or the mask |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unrecognised sub-opcode |
| old_out | output | 32 | Memory word read by the last operation |
| base_out | output | 32 | Updated base value of the last operation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (0 means a read) |
| mem_lock | output | 1 | Bus lock over the read-write pair |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge for the current request |
| mem_rdata | input | 32 | Read data, valid with the acknowledge of a read |

## Verification
With a memory that acknowledges each request on the cycle after it first sees it, `done` is due exactly four clock edges after the edge that takes `op_valid`. Those four edges are the read acknowledge, the capture of the read data, the write acknowledge, and the registered completion. `illegal` is due on the first edge after the strobe. The bench drives inputs on falling edges and counts falling edges until `done`, so every operation also checks that the latency is exactly four. Every other result is sampled on the falling edge where `done` or `illegal` is high.

// File: rtl/atomic_rmw_pkg.sv
// Shared types and sub-opcode constants for the atomic read-modify-write unit.
// Assumes a 6-bit sub-opcode. Bits [5:4] pick the addressing mode and the
// low nibble picks the operation.
package atomic_rmw_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [1:0] {
        AM_POST  = 2'b00,
        AM_PRE   = 2'b01,
        AM_SHORT = 2'b10
    } amode_e;

    typedef enum logic {
        RMW_MASK = 1'b0,
        RMW_CAS  = 1'b1
    } rmw_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } seq_state_e;

    localparam logic [3:0] NIB_CAS  = 4'h3;
    localparam logic [3:0] NIB_MASK = 4'h2;

endpackage

// File: rtl/atomic_rmw_decode.sv
// Sub-opcode decoder. It splits the code into an operation kind and an
// addressing mode, and flags any code outside the six legal ones.
// Assumes the code is stable while op_valid is high.
module atomic_rmw_decode
    import atomic_rmw_pkg::*;
(
    input  logic [OPC_W-1:0] code,
    output logic             legal,
    output rmw_kind_e        kind,
    output amode_e           mode
);
    logic [1:0] mode_bits;
    logic [3:0] op_nib;

    assign mode_bits = code[5:4];
    assign op_nib    = code[3:0];

    // Classify the code into kind, mode and legality.
    always_comb begin
        kind  = (op_nib == NIB_CAS) ? RMW_CAS : RMW_MASK;
        mode  = amode_e'(mode_bits);
        legal = ((op_nib == NIB_CAS) || (op_nib == NIB_MASK)) &&
                (mode_bits != 2'b11);
    end
endmodule

// File: rtl/atomic_rmw_agu.sv
// Address generation. It sign-extends the offset and forms both the access
// address and the updated base for the selected addressing mode.
// Assumes AW is wider than OFFW.
module atomic_rmw_agu
    import atomic_rmw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 10
) (
    input  logic [AW-1:0]   base,
    input  logic [OFFW-1:0] offset,
    input  amode_e          mode,
    output logic [AW-1:0]   addr,
    output logic [AW-1:0]   next_base
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] sum;

    assign sum = base + {{EXTW{offset[OFFW-1]}}, offset};

    // Pick the address and the written-back base for the mode.
    always_comb begin
        case (mode)
            AM_POST: begin
                addr      = base;
                next_base = sum;
            end
            AM_PRE: begin
                addr      = sum;
                next_base = sum;
            end
            default: begin
                addr      = sum;
                next_base = base;
            end
        endcase
    end
endmodule

// File: rtl/atomic_rmw_merge.sv
// Write-data former. For a conditional swap it gives the new word on a match
// and the old word otherwise. For a masked swap it merges the bits.
// Assumes old_word is the word returned by the read phase.
module atomic_rmw_merge
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  rmw_kind_e       kind,
    input  logic [DW-1:0]   new_word,
    input  logic [DW-1:0]   pair_word,
    input  logic [DW-1:0]   old_word,
    output logic [DW-1:0]   wr_word
);
    // Form the word to store for the current operation.
    always_comb begin
        if (kind == RMW_CAS)
            wr_word = (pair_word == old_word) ? new_word : old_word;
        else
            wr_word = (new_word & pair_word) | (old_word & ~pair_word);
    end
endmodule

// File: rtl/atomic_rmw_seq.sv
// Sequencer for the locked read-then-write pair. It latches the operands on
// the accepting edge, waits for the read acknowledge, then waits for the
// write acknowledge, and then pulses done.
// Assumes mem_ack is only high while a request is outstanding.
module atomic_rmw_seq
    import atomic_rmw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          legal,
    input  rmw_kind_e     kind,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] next_base,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] pair,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output seq_state_e    state,
    output rmw_kind_e     kind_q,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] base_q,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] pair_q,
    output logic [DW-1:0] old_q,
    output logic          done,
    output logic          illegal
);
    // Advance the read/write sequence and capture operands and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= RMW_MASK;
            addr_q  <= '0;
            base_q  <= '0;
            data_q  <= '0;
            pair_q  <= '0;
            old_q   <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (legal) begin
                            state  <= ST_READ;
                            kind_q <= kind;
                            addr_q <= addr;
                            base_q <= next_base;
                            data_q <= data;
                            pair_q <= pair;
                        end else begin
                            illegal <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        old_q <= mem_rdata;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
// Top of the atomic compare-swap and masked-swap unit. It connects the
// decoder, the address generator, the sequencer and the write-data former,
// and drives the locked memory port. Assumes a memory that acknowledges
// each request once.
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int OFFW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] op_code,
    input  logic [AW-1:0]    base_in,
    input  logic [OFFW-1:0]  offset_in,
    input  logic [DW-1:0]    data_in,
    input  logic [DW-1:0]    pair_in,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic [DW-1:0]    old_out,
    output logic [AW-1:0]    base_out,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata
);
    logic          dec_legal;
    rmw_kind_e     dec_kind;
    amode_e        dec_mode;
    logic [AW-1:0] agu_addr;
    logic [AW-1:0] agu_base;
    seq_state_e    state;
    rmw_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] base_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] pair_q;
    logic [DW-1:0] old_q;
    logic          start;

    assign start = op_valid && (state == ST_IDLE);

    atomic_rmw_decode u_dec (
        .code  (op_code),
        .legal (dec_legal),
        .kind  (dec_kind),
        .mode  (dec_mode)
    );

    atomic_rmw_agu #(.AW(AW), .OFFW(OFFW)) u_agu (
        .base      (base_in),
        .offset    (offset_in),
        .mode      (dec_mode),
        .addr      (agu_addr),
        .next_base (agu_base)
    );

    atomic_rmw_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .legal     (dec_legal),
        .kind      (dec_kind),
        .addr      (agu_addr),
        .next_base (agu_base),
        .data      (data_in),
        .pair      (pair_in),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .state     (state),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .base_q    (base_q),
        .data_q    (data_q),
        .pair_q    (pair_q),
        .old_q     (old_q),
        .done      (done),
        .illegal   (illegal)
    );

    atomic_rmw_merge #(.DW(DW)) u_merge (
        .kind      (kind_q),
        .new_word  (data_q),
        .pair_word (pair_q),
        .old_word  (old_q),
        .wr_word   (mem_wdata)
    );

    // Drive the memory port and status from the sequencer state.
    always_comb begin
        mem_req  = (state == ST_READ) || (state == ST_WRITE);
        mem_we   = (state == ST_WRITE);
        mem_lock = mem_req;
        mem_addr = addr_q;
        busy     = (state != ST_IDLE);
        old_out  = old_q;
        base_out = base_q;
    end
endmodule

// File: rtl/atomic_rmw_checker.sv
// Protocol checker for the atomic unit's memory port and status pulses.
// Assumes it is bound to atomic_rmw_unit and that reset is synchronous and
// active low.
module atomic_rmw_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_lock,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack
);
    // R9
    lock_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R9
    lock_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> (mem_req && !mem_we));

    // R9
    lock_bridges_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_lock && mem_req && mem_we && $stable(mem_addr)));

    // R9
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !done && $past(op_valid)));

    // R4
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we && mem_ack));

    // R12
    busy_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> !illegal);
endmodule

bind atomic_rmw_unit atomic_rmw_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_lock (mem_lock),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/atomic_rmw_unit_test.sv
// Directed bench for atomic_rmw_unit, with a one-cycle-latency word memory.
module atomic_rmw_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [31:0] base_in = '0;
    logic [9:0]  offset_in = '0;
    logic [31:0] data_in = '0;
    logic [31:0] pair_in = '0;
    logic        busy, done, illegal;
    logic [31:0] old_out, base_out;
    logic        mem_req, mem_we, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    atomic_rmw_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .base_in(base_in), .offset_in(offset_in), .data_in(data_in),
        .pair_in(pair_in), .busy(busy), .done(done), .illegal(illegal),
        .old_out(old_out), .base_out(base_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Word memory: each request is acknowledged on the edge after it is first seen.
    logic [31:0] mem [0:63];
    logic [31:0] rd_addr, wr_addr;
    int          rd_cnt, wr_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_addr   <= '0;
            wr_addr   <= '0;
            rd_cnt    <= 0;
            wr_cnt    <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:2]] <= mem_wdata;
                    wr_addr <= mem_addr;
                    wr_cnt  <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[7:2]];
                    rd_addr   <= mem_addr;
                    rd_cnt    <= rd_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one operation and count edges until done (or a timeout).
    task automatic do_op(input logic [5:0] opc, input logic [31:0] b,
                         input logic [9:0] off, input logic [31:0] d,
                         input logic [31:0] p, output int cyc,
                         output bit saw_ill, output bit saw_done);
        @(negedge clk);
        op_valid = 1'b1; op_code = opc; base_in = b; offset_in = off;
        data_in = d; pair_in = p;
        @(negedge clk);
        op_valid = 1'b0;
        cyc = 0;
        saw_ill = illegal;
        saw_done = done;
        while (!done && cyc < 12) begin
            @(negedge clk);
            cyc++;
            saw_done = done;
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !illegal, "R10 reset status idle", {29'b0, busy, done, illegal}, 32'h0);
        chk(!mem_req && !mem_lock, "R9 reset port quiet", {30'b0, mem_req, mem_lock}, 32'h0);
    endtask

    task automatic t_cas_equal();
        int cyc; bit il, dn;
        mem[6'h12] = 32'hAAAA5555;
        do_op(6'h23, 32'h40, 10'd8, 32'h12345678, 32'hAAAA5555, cyc, il, dn);
        chk(dn && cyc == 4, "R9 done latency four edges", cyc, 4);
        chk(mem[6'h12] == 32'h12345678, "R1 match stores data", mem[6'h12], 32'h12345678);
        chk(old_out == 32'hAAAA5555, "R4 old word returned cas", old_out, 32'hAAAA5555);
        chk(rd_addr == 32'h48 && wr_addr == 32'h48, "R5 short offset address", wr_addr, 32'h48);
        chk(base_out == 32'h40, "R5 short offset keeps base", base_out, 32'h40);
        chk(!mem_lock, "R9 lock released after write", mem_lock, 0);
    endtask

    task automatic t_cas_differ();
        int cyc; bit il, dn; int w0;
        mem[6'h12] = 32'hCAFEF00D;
        w0 = wr_cnt;
        do_op(6'h23, 32'h40, 10'd8, 32'h11111111, 32'h0, cyc, il, dn);
        chk(mem[6'h12] == 32'hCAFEF00D, "R2 mismatch keeps word", mem[6'h12], 32'hCAFEF00D);
        chk(wr_cnt == w0 + 1, "R2 write phase still issued", wr_cnt, w0 + 1);
        chk(old_out == 32'hCAFEF00D, "R4 old word on mismatch", old_out, 32'hCAFEF00D);
    endtask

    task automatic t_mask();
        int cyc; bit il, dn;
        mem[6'h20] = 32'hF0F0F0F0;
        do_op(6'h22, 32'h80, 10'd0, 32'h12345678, 32'h0000FFFF, cyc, il, dn);
        chk(mem[6'h20] == 32'hF0F05678, "R3 masked merge", mem[6'h20], 32'hF0F05678);
        chk(old_out == 32'hF0F0F0F0, "R4 old word masked", old_out, 32'hF0F0F0F0);
        chk(dn && cyc == 4, "R3 masked latency", cyc, 4);
    endtask

    task automatic t_post();
        int cyc; bit il, dn;
        mem[6'h08] = 32'h00000005;
        do_op(6'h03, 32'h20, 10'h010, 32'h9, 32'h5, cyc, il, dn);
        chk(wr_addr == 32'h20, "R6 post uses old base", wr_addr, 32'h20);
        chk(base_out == 32'h30, "R6 post updates base", base_out, 32'h30);
        chk(mem[6'h08] == 32'h9, "R6 post cas stored", mem[6'h08], 32'h9);
    endtask

    task automatic t_pre();
        int cyc; bit il, dn;
        mem[6'h0C] = 32'hFFFFFFFF;
        do_op(6'h12, 32'h20, 10'h010, 32'h0, 32'hFF00FF00, cyc, il, dn);
        chk(wr_addr == 32'h30, "R7 pre uses new base", wr_addr, 32'h30);
        chk(base_out == 32'h30, "R7 pre updates base", base_out, 32'h30);
        chk(mem[6'h0C] == 32'h00FF00FF, "R7 pre masked stored", mem[6'h0C], 32'h00FF00FF);
    endtask

    task automatic t_negoff();
        int cyc; bit il, dn;
        do_op(6'h13, 32'h60, 10'h3F8, 32'h1, 32'h2, cyc, il, dn);
        chk(wr_addr == 32'h58, "R11 negative pre address", wr_addr, 32'h58);
        chk(base_out == 32'h58, "R11 negative pre base", base_out, 32'h58);
        do_op(6'h02, 32'h60, 10'h3FC, 32'h1, 32'h2, cyc, il, dn);
        chk(wr_addr == 32'h60, "R11 negative post address", wr_addr, 32'h60);
        chk(base_out == 32'h5C, "R11 negative post base", base_out, 32'h5C);
    endtask

    task automatic t_illegal();
        int cyc; bit il, dn; int r0;
        r0 = rd_cnt;
        do_op(6'h21, 32'h40, 10'd0, 32'h0, 32'h0, cyc, il, dn);
        chk(il, "R10 illegal pulse", il, 1);
        chk(!dn, "R10 no done after illegal", dn, 0);
        chk(rd_cnt == r0, "R10 no memory access", rd_cnt, r0);
        chk(!illegal, "R10 illegal lasts one cycle", illegal, 0);
    endtask

    task automatic t_busy();
        bit seen_ill; int cyc;
        mem[6'h04] = 32'h77;
        @(negedge clk);
        op_valid = 1'b1; op_code = 6'h23; base_in = 32'h10; offset_in = 10'd0;
        data_in = 32'h88; pair_in = 32'h77;
        @(negedge clk);
        op_code = 6'h00; base_in = 32'h80; data_in = 32'h5; pair_in = 32'h0;
        seen_ill = 1'b0;
        cyc = 0;
        while (!done && cyc < 12) begin
            @(negedge clk);
            cyc++;
            if (illegal) seen_ill = 1'b1;
        end
        op_valid = 1'b0;
        chk(!seen_ill, "R12 strobe ignored while busy", seen_ill, 0);
        chk(mem[6'h04] == 32'h88 && base_out == 32'h10, "R12 first operation kept", mem[6'h04], 32'h88);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_sweep();
        int cyc; bit il, dn; bit exp_legal;
        for (int c = 0; c < 64; c++) begin
            exp_legal = (c == 'h23) || (c == 'h03) || (c == 'h13) ||
                        (c == 'h22) || (c == 'h02) || (c == 'h12);
            do_op(c[5:0], 32'h0, 10'd0, 32'h0, 32'h0, cyc, il, dn);
            chk((dn == exp_legal) && (il == !exp_legal), "R8 sub-opcode legality",
                {24'b0, c[5:0], dn, il}, {24'b0, c[5:0], exp_legal, !exp_legal});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cas_equal();
        t_cas_differ();
        t_mask();
        t_post();
        t_pre();
        t_negoff();
        t_illegal();
        t_busy();
        t_sweep();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule